// File: doc/BRIEF.md
# Grouped TDM Serial Port Aligner

This block handles the serial side of one group of four time-division multiplexed lines. On the receive side it samples each serial input once per bit period and packs the bits, most significant first, into timeslot bytes. Each finished byte is reported with a one-cycle strobe, the byte value and the timeslot number. On the transmit side it asks for one byte per timeslot, by timeslot number, and shifts that byte out serially. Timing comes from a base tick enable, `bit_en`, that pulses at the fastest line rate, and from a frame pulse that marks position zero of the frame. One frame always lasts `64*SLOT_UNIT` base ticks.

Each direction has its own 2-bit rate code: 0 = x1, 1 = x2, 2 = x4, 3 = x8. At code c one data bit lasts `P = 8 >> c` base ticks, and a frame carries `SLOT_UNIT << c` timeslots per line. The code also decides which lines carry data. Code 3 uses line 0 only, code 2 uses lines 0 and 1, and codes 0 and 1 use all four lines. The receive sampling point can be delayed by 0 to 7 whole bit periods. The transmit frame boundary can be advanced by 0 to 7 whole bit periods.

Top module: `tdm_group_port`

## Requirements
- R1: An active receive line gives exactly `SLOT_UNIT << in_rate` byte strobes per frame. Line 0 is always active, line 1 is active for `in_rate` codes 0 to 2, and lines 2 and 3 are active for codes 0 and 1.
- R2: A line that is inactive at the current rate never raises its `rx_valid` bit, whatever its serial input carries, and drives its `tx_ser` bit low.
- R3: Receive bytes are assembled most significant bit first. Line i's byte appears on `rx_data[8i+7:8i]` with `rx_valid[i]` high for one clock, one clock after the tick that samples the byte's last bit. `rx_slot` gives the timeslot of that byte.
- R4: The frame pulse, taken on a tick, sets the frame position to zero. Reported timeslots then count up by one per byte and wrap after `SLOT_UNIT << in_rate` slots.
- R5: With input delay d, bit 7 of timeslot 0 is sampled on base tick `d*P` after the frame boundary. The strobe for slot 0 therefore follows the tick at frame position `(7+d)*P`.
- R6: With zero advancement, bit 7 of slot 0 appears on `tx_ser` in the clock after the frame-boundary tick. The remaining bits follow most significant first.
- R7: An advancement of a moves the whole transmit frame `a*P` base ticks earlier, wrapping into the end of the previous frame.
- R8: Each transmit bit stays constant for P base ticks. The byte sent in a timeslot is the `tx_data` lane value present while `tx_slot` shows that timeslot at its first bit tick.
- R9: Receive and transmit rates, delay and advancement are set independently of one another.
- R10: After reset, all `rx_valid` and `tx_ser` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Base tick enable, one pulse per fastest-rate bit |
| frame_sync | input | 1 | Frame pulse; with bit_en marks frame position 0 |
| in_rate | input | 2 | Receive rate code |
| out_rate | input | 2 | Transmit rate code |
| in_delay | input | 3 | Receive sampling delay in bit periods |
| out_advance | input | 3 | Transmit boundary advancement in bit periods |
| rx_ser | input | 4 | Serial receive lines |
| rx_valid | output | 4 | Per-line byte strobe |
| rx_data | output | 32 | Received bytes, 8 bits per line |
| rx_slot | output | SLOT_UNIT log2 + 3 | Timeslot of the strobed bytes |
| tx_data | input | 32 | Bytes to transmit for `tx_slot`, 8 bits per line |
| tx_slot | output | SLOT_UNIT log2 + 3 | Timeslot whose bytes are requested |
| tx_ser | output | 4 | Serial transmit lines |

## Verification
The hardest situation to reach is a frame boundary that falls inside a byte. This happens on the receive side with a nonzero delay and on the transmit side with a nonzero advancement. The last or first bits of a frame then cross the boundary, and the slot count must wrap on the correct bit. The stimulus generates the serial inputs from a frame model that already contains the delay, at each rate. It runs a full frame so the lanes settle, then checks a second full frame across the wrap. One scenario also issues a frame pulse in mid-frame to force a resynchronisation.

// File: rtl/tdm_grp_pkg.sv
// Shared constants and helpers for the grouped TDM serial port.
// Assumes rate codes 0..3 stand for x1, x2, x4 and x8 of the slowest rate.
package tdm_grp_pkg;
    localparam int LANES = 4;

    // Mask of lines that carry data at a given rate code.
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] rate);
        case (rate)
            2'd3:    lane_mask = 4'b0001;
            2'd2:    lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    // log2 of the number of base ticks in one data bit.
    function automatic logic [1:0] bit_len_log2(input logic [1:0] rate);
        bit_len_log2 = 2'd3 - rate;
    endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
// Frame position counter in base ticks.
// Assumes the frame length is a power of two (2**FW ticks), so it wraps naturally.
module tdm_frame_timer #(
    parameter int FW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          frame_sync,
    output logic [FW-1:0] pos
);
    logic [FW-1:0] cnt;

    // Position of the current tick; the frame pulse forces zero.
    always_comb pos = frame_sync ? '0 : cnt;

    // Advance the expected position on every base tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (bit_en) cnt <= pos + FW'(1);
    end

    assert_frame_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_sync) |=> (cnt == FW'(1)));
endmodule

// File: rtl/tdm_phase.sv
// Maps a frame position to bit index and timeslot for one direction.
// ADVANCE=0 subtracts the shift (receive delay), ADVANCE=1 adds it (transmit advance).
module tdm_phase #(
    parameter int FW      = 9,
    parameter bit ADVANCE = 1'b0,
    localparam int SW     = FW - 3
) (
    input  logic [FW-1:0] pos,
    input  logic [1:0]    rate,
    input  logic [2:0]    shift_bits,
    output logic          bit_start,
    output logic [2:0]    bit_idx,
    output logic [SW-1:0] slot
);
    import tdm_grp_pkg::*;

    logic [1:0]    len_l2;
    logic [FW-1:0] offset;
    logic [FW-1:0] phase;
    logic [FW-1:0] bit_num;

    // Bit length and offset of the shifted boundary in base ticks.
    always_comb begin
        len_l2 = bit_len_log2(rate);
        offset = {{(FW-3){1'b0}}, shift_bits} << len_l2;
    end

    generate
        if (ADVANCE) begin : g_adv
            // Transmit side sees the frame earlier.
            always_comb phase = pos + offset;
        end else begin : g_dly
            // Receive side sees the frame later.
            always_comb phase = pos - offset;
        end
    endgenerate

    // Bit number within the frame, its position in the byte, and the slot.
    always_comb begin
        bit_num   = phase >> len_l2;
        bit_idx   = bit_num[2:0];
        slot      = bit_num[FW-1:3];
        bit_start = ((pos & ((FW'(1) << len_l2) - FW'(1))) == '0);
    end
endmodule

// File: rtl/tdm_rx_lane.sv
// Serial-to-byte shifter for one receive line.
// Assumes sample pulses once per bit and bit_idx==7 marks the byte's last bit.
module tdm_rx_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       active,
    input  logic       din,
    input  logic [2:0] bit_idx,
    output logic       valid,
    output logic [7:0] data
);
    logic [6:0] shreg;

    // Shift in one bit per sample and publish the byte on its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (sample && active) begin
                shreg <= {shreg[5:0], din};
                if (bit_idx == 3'd7) begin
                    data  <= {shreg, din};
                    valid <= 1'b1;
                end
            end
        end
    end

    assert_idle_lane_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !valid);
    assert_strobe_after_last_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(sample && active && (bit_idx == 3'd7)));
endmodule

// File: rtl/tdm_tx_lane.sv
// Byte-to-serial shifter for one transmit line.
// Assumes step pulses at each bit start and bit_idx==0 marks a byte's first bit.
module tdm_tx_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       active,
    input  logic [7:0] load_byte,
    input  logic [2:0] bit_idx,
    output logic       ser
);
    logic [6:0] shreg;

    // Load at byte start, shift at other bit starts, hold low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser   <= 1'b0;
            shreg <= '0;
        end else if (!active) begin
            ser   <= 1'b0;
        end else if (step) begin
            if (bit_idx == 3'd0) {ser, shreg} <= load_byte;
            else                 {ser, shreg} <= {shreg, 1'b0};
        end
    end

    assert_idle_line_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ser == 1'b0));
    assert_bit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !step) |=> $stable(ser));
endmodule

// File: rtl/tdm_group_port.sv
// Receive and transmit serial port for one group of four TDM lines.
// Assumes bit_en ticks at the fastest rate and a frame is 64*SLOT_UNIT ticks,
// SLOT_UNIT a power of two.
module tdm_group_port #(
    parameter int SLOT_UNIT = 8,
    localparam int FW = $clog2(SLOT_UNIT) + 6,
    localparam int SW = FW - 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          frame_sync,
    input  logic [1:0]    in_rate,
    input  logic [1:0]    out_rate,
    input  logic [2:0]    in_delay,
    input  logic [2:0]    out_advance,
    input  logic [3:0]    rx_ser,
    output logic [3:0]    rx_valid,
    output logic [31:0]   rx_data,
    output logic [SW-1:0] rx_slot,
    input  logic [31:0]   tx_data,
    output logic [SW-1:0] tx_slot,
    output logic [3:0]    tx_ser
);
    import tdm_grp_pkg::*;

    logic [FW-1:0]    pos;
    logic             in_start, out_start;
    logic [2:0]       in_idx, out_idx;
    logic [SW-1:0]    in_slot;
    logic [LANES-1:0] in_mask, out_mask;
    logic             rx_sample, tx_step;

    tdm_frame_timer #(.FW(FW)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync), .pos(pos)
    );

    tdm_phase #(.FW(FW), .ADVANCE(1'b0)) u_in_phase (
        .pos(pos), .rate(in_rate), .shift_bits(in_delay),
        .bit_start(in_start), .bit_idx(in_idx), .slot(in_slot)
    );

    tdm_phase #(.FW(FW), .ADVANCE(1'b1)) u_out_phase (
        .pos(pos), .rate(out_rate), .shift_bits(out_advance),
        .bit_start(out_start), .bit_idx(out_idx), .slot(tx_slot)
    );

    // Active lines and per-tick strobes for each direction.
    always_comb begin
        in_mask   = lane_mask(in_rate);
        out_mask  = lane_mask(out_rate);
        rx_sample = bit_en && in_start;
        tx_step   = bit_en && out_start;
    end

    // Timeslot reported alongside completed receive bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rx_slot <= '0;
        else if (rx_sample && in_idx == 3'd7)    rx_slot <= in_slot;
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            tdm_rx_lane u_rx (
                .clk(clk), .rst_n(rst_n), .sample(rx_sample), .active(in_mask[i]),
                .din(rx_ser[i]), .bit_idx(in_idx),
                .valid(rx_valid[i]), .data(rx_data[8*i +: 8])
            );
            tdm_tx_lane u_tx (
                .clk(clk), .rst_n(rst_n), .step(tx_step), .active(out_mask[i]),
                .load_byte(tx_data[8*i +: 8]), .bit_idx(out_idx), .ser(tx_ser[i])
            );
        end
    endgenerate

    assert_slot_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_valid) |-> (int'(rx_slot) < (SLOT_UNIT << $past(in_rate))));
endmodule

// File: tb/tdm_group_port_test.sv
module tdm_group_port_test;
    localparam int SU = 8;
    localparam int F  = 64 * SU;
    localparam int SW = $clog2(SU) + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          frame_sync = 1'b0;
    logic [1:0]    in_rate = 2'd0, out_rate = 2'd0;
    logic [2:0]    in_delay = 3'd0, out_advance = 3'd0;
    logic [3:0]    rx_ser = 4'h0;
    logic [3:0]    rx_valid;
    logic [31:0]   rx_data;
    logic [SW-1:0] rx_slot;
    logic [31:0]   tx_data;
    logic [SW-1:0] tx_slot;
    logic [3:0]    tx_ser;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tdm_group_port #(.SLOT_UNIT(SU)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
        .in_rate(in_rate), .out_rate(out_rate), .in_delay(in_delay),
        .out_advance(out_advance), .rx_ser(rx_ser), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_slot(rx_slot), .tx_data(tx_data),
        .tx_slot(tx_slot), .tx_ser(tx_ser)
    );

    function automatic logic [7:0] rx_pat(int ln, int s);
        return {ln[1:0], s[5:0]} ^ 8'hA5;
    endfunction
    function automatic logic [7:0] tx_pat(int ln, int s);
        return {s[5:0], ln[1:0]} ^ 8'h3C;
    endfunction

    // Transmit bytes are served from the requested timeslot (R8).
    for (genvar g = 0; g < 4; g++) begin : g_feed
        assign tx_data[8*g +: 8] = tx_pat(g, int'(tx_slot));
    end

    function automatic bit lane_on(int rate, int ln);
        if (rate == 3) return ln == 0;
        if (rate == 2) return ln < 2;
        return 1'b1;
    endfunction

    // Frame-model state and per-scenario tallies.
    int pos = 0, last_pos = 0;
    bit mon_en = 1'b0;
    int rx_cnt[4], tx_bad[4];
    int rx_bad, seq_bad, prev_slot, slot0_pos;

    function automatic logic rx_bit(int ln, int p);
        int per = 8 >> in_rate;
        int ph  = ((p - int'(in_delay) * per) % F + F) % F;
        int bn  = ph / per;
        logic [7:0] b = rx_pat(ln, bn / 8);
        return b[7 - (bn % 8)];
    endfunction

    function automatic logic tx_exp(int ln, int p);
        int per = 8 >> out_rate;
        int ob  = (p + int'(out_advance) * per) % F;
        int bn  = ob / per;
        logic [7:0] b = tx_pat(ln, bn / 8);
        if (!lane_on(out_rate, ln)) return 1'b0;
        return b[7 - (bn % 8)];
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic monitor();
        int nslots = SU << in_rate;
        for (int i = 0; i < 4; i++) begin
            if (rx_valid[i]) begin
                rx_cnt[i]++;
                if (rx_data[8*i +: 8] != rx_pat(i, int'(rx_slot))) rx_bad++;
                if (i == 0) begin
                    if (prev_slot >= 0 && int'(rx_slot) != (prev_slot + 1) % nslots) seq_bad++;
                    prev_slot = int'(rx_slot);
                    if (rx_slot == '0 && slot0_pos < 0) slot0_pos = last_pos;
                end
            end
            if (tx_ser[i] != tx_exp(i, last_pos)) tx_bad[i]++;
        end
    endtask

    // One clock: observe, then drive inputs for the next edge.
    task automatic step(bit tk, bit force_fs);
        bit fs;
        int p;
        @(negedge clk);
        if (mon_en) monitor();
        bit_en = tk;
        frame_sync = 1'b0;
        if (tk) begin
            fs = force_fs || (pos == 0);
            p  = fs ? 0 : pos;
            frame_sync = fs;
            for (int i = 0; i < 4; i++)
                rx_ser[i] = lane_on(in_rate, i) ? rx_bit(i, p) : 1'b1;
            last_pos = p;
            pos = (p + 1) % F;
        end
    endtask

    task automatic run_ticks(int n);
        repeat (n) begin
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
        end
    endtask

    // Configure, settle one frame, check one full frame.
    task automatic run_case(string name, int ir, int orr, int d, int a, bit resync);
        int per = 8 >> ir;
        in_rate = 2'(ir); out_rate = 2'(orr); in_delay = 3'(d); out_advance = 3'(a);
        run_ticks(F);
        if (resync) begin
            run_ticks(100);
            step(1'b0, 1'b0);
            step(1'b1, 1'b1);
            run_ticks(F);
        end
        for (int i = 0; i < 4; i++) begin rx_cnt[i] = 0; tx_bad[i] = 0; end
        rx_bad = 0; seq_bad = 0; prev_slot = -1; slot0_pos = -1;
        mon_en = 1'b1;
        run_ticks(F);
        mon_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (lane_on(ir, i))
                check(rx_cnt[i] == (SU << ir), $sformatf("%s R1 lane %0d strobe count", name, i),
                      rx_cnt[i], SU << ir);
            else
                check(rx_cnt[i] == 0, $sformatf("%s R2 idle lane %0d strobes", name, i),
                      rx_cnt[i], 0);
            check(tx_bad[i] == 0, $sformatf("%s R6 R7 R8 R9 lane %0d tx mismatches", name, i),
                  tx_bad[i], 0);
        end
        check(rx_bad == 0, $sformatf("%s R3 rx byte mismatches", name), rx_bad, 0);
        check(seq_bad == 0, $sformatf("%s R4 slot sequence breaks", name), seq_bad, 0);
        check(slot0_pos == ((7 + d) * per) % F, $sformatf("%s R5 slot0 strobe position", name),
              slot0_pos, ((7 + d) * per) % F);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_valid == 4'h0, "R10 rx_valid after reset", int'(rx_valid), 0);
        check(tx_ser == 4'h0, "R10 tx_ser after reset", int'(tx_ser), 0);
    endtask

    task automatic test_all_lanes_slowest();  run_case("x1",        0, 0, 0, 0, 1'b0); endtask
    task automatic test_single_lane_fast();   run_case("x8",        3, 3, 2, 1, 1'b0); endtask
    task automatic test_mixed_rates();        run_case("x4in-x2out", 2, 1, 5, 3, 1'b0); endtask
    task automatic test_max_shifts();         run_case("x2in-x8out", 1, 3, 7, 7, 1'b0); endtask
    task automatic test_slow_in_fast_out();   run_case("x1in-x4out", 0, 2, 3, 0, 1'b0); endtask
    task automatic test_midframe_resync();    run_case("resync",    2, 2, 0, 2, 1'b1); endtask

    initial begin
        test_reset();
        test_all_lanes_slowest();
        test_single_lane_fast();
        test_mixed_rates();
        test_max_shifts();
        test_slow_in_fast_out();
        test_midframe_resync();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule